// File: doc/BRIEF.md
# Instruction Packet Issue Controller

This block sits between instruction fetch and an on-chip network that replaces a conventional execution pipeline. Every accepted instruction becomes one network packet. The packet carries the instruction word, its program counter, a window tag, a fault flag and a list of up to five network addresses. That list is the itinerary of functional elements the instruction has to visit. The packet is launched toward the first address on the list. The last hop always leads back to this controller.

Before accepting an instruction, the block needs three things: a clear hazard verdict from an external dependency checker, a free slot in its in-flight window, and room in its output register. An external element allocator supplies one network address per hop, selected by element kind. Packets that come back free their window slot, possibly out of order. They are forwarded to the dependency checker one cycle later so their hazards can be released. Returning packets also steer the program counter: a faulted packet sends it to a fixed trap vector, and a resolved branch loads its target.

Top module: `pkt_issue_ctrl`

## Requirements
- R1: One cycle after an instruction is accepted (`fet_valid` and `fet_ready` both high at a clock edge), `tx_valid` is high. The packet carries that instruction word, its class, the `fetch_pc` value it was accepted under, and `tx_dest` equal to route entry 0 (`tx_route[ADDR_W-1:0]`).
- R2: Element kinds are encoded as none=0, register file=1, ALU=2, FPU=3, memory=4, return-home=5. Route entry i sits at `tx_route[i*ADDR_W +: ADDR_W]`. The itinerary for each class is:
  - class 0 (integer): 1,2,1,5
  - class 1 (load): 1,2,4,1,5
  - class 2 (store): 1,2,4,5
  - class 3 (float): 1,3,1,5
  - class 4 (branch): 1,2,5
  - class 5 (window shift): 2,1,5
  
  A home hop carries `SELF_ADDR`, unused entries are zero, any other hop i carries `alloc_addr[i*ADDR_W +: ADDR_W]`, and `tx_hops` is the number of used entries.
- R3: Classes 6 and 7 are issued with a single home hop, `tx_hops`=1 and `tx_fault`=1. Defined classes are issued with `tx_fault`=0.
- R4: At most `WINDOW` instructions are in flight. Each new packet takes the lowest-numbered free slot as `tx_tag`, and `fet_ready` stays low while every slot is occupied. A return with `rx_valid` frees the slot named by `rx_tag`.
- R5: `fet_ready` is low while `dep_ok` is low. `dep_claim` is high exactly in the cycles where an instruction is accepted.
- R6: While `tx_valid` is high and `tx_ready` is low, the packet on the output port stays unchanged and `fet_ready` is low.
- R7: After reset, `fetch_pc` equals `RESET_PC`. Each accepted instruction advances it by `PC_STEP` (4).
- R8: A return with `rx_fault`=1 sets `fetch_pc` to `TRAP_VEC` on the next cycle, whatever the return's class.
- R9: A return of class 4 with `rx_fault`=0 sets `fetch_pc` to `rx_target` on the next cycle.
- R10: If a redirect (R8/R9) and an acceptance fall in the same cycle, the redirect wins over the PC advance. `fet_ready` is low for the one cycle after any redirecting return.
- R11: Every return is presented on the release port one cycle later, with `rel_valid` high and the returning instruction word and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | output | WORD_W | Address of the next instruction to fetch |
| fet_valid | input | 1 | Fetch presents an instruction |
| fet_ready | output | 1 | Controller accepts the presented instruction |
| fet_instr | input | WORD_W | Instruction word (also observed by the dependency checker) |
| fet_class | input | 3 | Instruction class code |
| dep_ok | input | 1 | Dependency checker reports the presented instruction hazard-free |
| dep_claim | output | 1 | Accepted this cycle; checker records destinations |
| alloc_kind | output | MAX_HOPS*3 | Element kind wanted at each hop |
| alloc_addr | input | MAX_HOPS*ADDR_W | Allocator's network address for each hop |
| alloc_take | output | 1 | Allocator advances its rotation |
| tx_valid | output | 1 | Outgoing packet valid |
| tx_ready | input | 1 | Network accepts outgoing packet |
| tx_dest | output | ADDR_W | First destination |
| tx_route | output | MAX_HOPS*ADDR_W | Ordered destination list |
| tx_hops | output | HOP_W | Number of used route entries |
| tx_instr | output | WORD_W | Instruction word |
| tx_pc | output | WORD_W | Instruction address |
| tx_class | output | 3 | Instruction class |
| tx_tag | output | TAG_W | Window slot index |
| tx_fault | output | 1 | Packet pre-marked as failed |
| rx_valid | input | 1 | Returning packet valid |
| rx_instr | input | WORD_W | Returning instruction word |
| rx_class | input | 3 | Returning class |
| rx_tag | input | TAG_W | Returning slot index |
| rx_fault | input | 1 | Execution failed |
| rx_target | input | WORD_W | Resolved branch target |
| rel_valid | output | 1 | Release to dependency checker |
| rel_instr | output | WORD_W | Released instruction word |
| rel_tag | output | TAG_W | Released slot index |

## Verification
The two functions that can collide are acceptance of a new instruction and a redirecting return: both want to write the program counter and the slot map in the same cycle. The bench sets up this collision by holding a branch in flight and then, in a single cycle, presenting a fresh instruction together with that branch's return. It then checks four things: the PC holds the branch target rather than the incremented address; the new packet carries the pre-redirect PC and the next free tag; the release port shows the branch's tag; and fetch is held off for the following cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int KIND_W    = 3;
   localparam int CLS_W     = 3;
   localparam int BASE_HOPS = 5;

   typedef enum logic [KIND_W-1:0] {
      EK_NONE = 3'd0,
      EK_REGF = 3'd1,
      EK_ALU  = 3'd2,
      EK_FPU  = 3'd3,
      EK_MEM  = 3'd4,
      EK_HOME = 3'd5
   } elem_kind_e;

   localparam logic [CLS_W-1:0] CL_INT    = 3'd0;
   localparam logic [CLS_W-1:0] CL_LOAD   = 3'd1;
   localparam logic [CLS_W-1:0] CL_STORE  = 3'd2;
   localparam logic [CLS_W-1:0] CL_FP     = 3'd3;
   localparam logic [CLS_W-1:0] CL_BRANCH = 3'd4;
   localparam logic [CLS_W-1:0] CL_WSHIFT = 3'd5;

   typedef struct packed {
      logic [BASE_HOPS-1:0][KIND_W-1:0] hop;
      logic [2:0]                       count;
      logic                             bad;
   } itinerary_t;

   function automatic itinerary_t plan_route(input logic [CLS_W-1:0] cls);
      itinerary_t r;
      r.hop   = '0;
      r.count = 3'd0;
      r.bad   = 1'b0;
      case (cls)
         CL_INT: begin
            r.hop[0] = EK_REGF; r.hop[1] = EK_ALU; r.hop[2] = EK_REGF;
            r.hop[3] = EK_HOME; r.count = 3'd4;
         end
         CL_LOAD: begin
            r.hop[0] = EK_REGF; r.hop[1] = EK_ALU; r.hop[2] = EK_MEM;
            r.hop[3] = EK_REGF; r.hop[4] = EK_HOME; r.count = 3'd5;
         end
         CL_STORE: begin
            r.hop[0] = EK_REGF; r.hop[1] = EK_ALU; r.hop[2] = EK_MEM;
            r.hop[3] = EK_HOME; r.count = 3'd4;
         end
         CL_FP: begin
            r.hop[0] = EK_REGF; r.hop[1] = EK_FPU; r.hop[2] = EK_REGF;
            r.hop[3] = EK_HOME; r.count = 3'd4;
         end
         CL_BRANCH: begin
            r.hop[0] = EK_REGF; r.hop[1] = EK_ALU; r.hop[2] = EK_HOME;
            r.count = 3'd3;
         end
         CL_WSHIFT: begin
            r.hop[0] = EK_ALU; r.hop[1] = EK_REGF; r.hop[2] = EK_HOME;
            r.count = 3'd3;
         end
         default: begin
            r.hop[0] = EK_HOME; r.count = 3'd1; r.bad = 1'b1;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pic_route_gen.sv
module pic_route_gen
   import pic_pkg::*;
#(
   parameter int MAX_HOPS = 5,
   parameter int HOP_W    = 3
) (
   input  logic [CLS_W-1:0]           cls,
   output logic [MAX_HOPS*KIND_W-1:0] kinds,
   output logic [HOP_W-1:0]           hops,
   output logic                       bad
);

   itinerary_t plan;

   always_comb begin
      plan = plan_route(cls);
   end

   assign hops = HOP_W'(plan.count);
   assign bad  = plan.bad;

   for (genvar i = 0; i < MAX_HOPS; i++) begin : g_hop
      if (i < BASE_HOPS) begin : g_live
         assign kinds[i*KIND_W +: KIND_W] = plan.hop[i];
      end else begin : g_pad
         assign kinds[i*KIND_W +: KIND_W] = '0;
      end
   end

endmodule

// File: rtl/pic_slot_pool.sv
module pic_slot_pool #(
   parameter int SLOTS = 16,
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give,
   input  logic [TAG_W-1:0] give_tag,
   output logic             has_free,
   output logic [TAG_W-1:0] free_tag
);

   logic [SLOTS-1:0] busy_q;

   // lowest free index wins: scan downward so the last hit is the smallest
   always_comb begin
      has_free = 1'b0;
      free_tag = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!busy_q[i]) begin
            has_free = 1'b1;
            free_tag = TAG_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         if (give) busy_q[give_tag] <= 1'b0;
         if (take) busy_q[free_tag] <= 1'b1;
      end
   end

   AST_RETURN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> busy_q[give_tag]); // R4
   AST_TAG_NOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy_q[$past(free_tag)]); // R4

endmodule

// File: rtl/pic_pc_steer.sv
module pic_pc_steer #(
   parameter int               WORD_W   = 32,
   parameter logic [WORD_W-1:0] RESET_PC = '0,
   parameter logic [WORD_W-1:0] TRAP_VEC = '0,
   parameter int               PC_STEP  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              ret_v,
   input  logic              ret_fault,
   input  logic              ret_branch,
   input  logic [WORD_W-1:0] ret_target,
   output logic [WORD_W-1:0] pc,
   output logic              redir_hold
);

   localparam logic [WORD_W-1:0] STEP = WORD_W'(PC_STEP);

   logic trap_now, jump_now;
   assign trap_now = ret_v && ret_fault;
   assign jump_now = ret_v && !ret_fault && ret_branch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc         <= RESET_PC;
         redir_hold <= 1'b0;
      end else begin
         redir_hold <= trap_now || jump_now;
         if (trap_now)      pc <= TRAP_VEC;
         else if (jump_now) pc <= ret_target;
         else if (adv)      pc <= pc + STEP;
      end
   end

   AST_TRAP_PC: assert property (@(posedge clk) disable iff (!rst_n)
      ret_v && ret_fault |=> pc == TRAP_VEC); // R8
   AST_BRANCH_PC: assert property (@(posedge clk) disable iff (!rst_n)
      ret_v && !ret_fault && ret_branch |=> pc == $past(ret_target)); // R9
   AST_STEP_PC: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !ret_v |=> pc == $past(pc) + STEP); // R7

endmodule

// File: rtl/pkt_issue_ctrl.sv
module pkt_issue_ctrl
   import pic_pkg::*;
#(
   parameter int                WORD_W    = 32,
   parameter int                ADDR_W    = 4,
   parameter int                WINDOW    = 16,
   parameter int                MAX_HOPS  = 5,
   parameter logic [ADDR_W-1:0] SELF_ADDR = 'd1,
   parameter logic [WORD_W-1:0] RESET_PC  = 'h100,
   parameter logic [WORD_W-1:0] TRAP_VEC  = 'h40,
   parameter int                PC_STEP   = 4,
   localparam int               TAG_W     = $clog2(WINDOW),
   localparam int               HOP_W     = $clog2(MAX_HOPS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   output logic [WORD_W-1:0]            fetch_pc,
   input  logic                         fet_valid,
   output logic                         fet_ready,
   input  logic [WORD_W-1:0]            fet_instr,
   input  logic [2:0]                   fet_class,
   input  logic                         dep_ok,
   output logic                         dep_claim,
   output logic [MAX_HOPS*3-1:0]        alloc_kind,
   input  logic [MAX_HOPS*ADDR_W-1:0]   alloc_addr,
   output logic                         alloc_take,
   output logic                         tx_valid,
   input  logic                         tx_ready,
   output logic [ADDR_W-1:0]            tx_dest,
   output logic [MAX_HOPS*ADDR_W-1:0]   tx_route,
   output logic [HOP_W-1:0]             tx_hops,
   output logic [WORD_W-1:0]            tx_instr,
   output logic [WORD_W-1:0]            tx_pc,
   output logic [2:0]                   tx_class,
   output logic [TAG_W-1:0]             tx_tag,
   output logic                         tx_fault,
   input  logic                         rx_valid,
   input  logic [WORD_W-1:0]            rx_instr,
   input  logic [2:0]                   rx_class,
   input  logic [TAG_W-1:0]             rx_tag,
   input  logic                         rx_fault,
   input  logic [WORD_W-1:0]            rx_target,
   output logic                         rel_valid,
   output logic [WORD_W-1:0]            rel_instr,
   output logic [TAG_W-1:0]             rel_tag
);

   // ---------------- elaboration checks ----------------
   if (WINDOW < 2) begin : g_chk_window
      $error("pkt_issue_ctrl: WINDOW must be at least 2");
   end
   if (MAX_HOPS < BASE_HOPS) begin : g_chk_hops
      $error("pkt_issue_ctrl: MAX_HOPS must cover the longest itinerary");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("pkt_issue_ctrl: ADDR_W too narrow");
   end
   if (PC_STEP < 1) begin : g_chk_step
      $error("pkt_issue_ctrl: PC_STEP must be positive");
   end

   // ---------------- internal signals ----------------
   logic                        fire;
   logic                        any_free;
   logic [TAG_W-1:0]            pick_tag;
   logic                        redir_hold;
   logic [MAX_HOPS*KIND_W-1:0]  kinds;
   logic [HOP_W-1:0]            hops_n;
   logic                        bad_n;
   logic [MAX_HOPS*ADDR_W-1:0]  route_n;
   logic                        out_v;

   // ---------------- itinerary ----------------
   pic_route_gen #(
      .MAX_HOPS (MAX_HOPS),
      .HOP_W    (HOP_W)
   ) u_route (
      .cls   (fet_class),
      .kinds (kinds),
      .hops  (hops_n),
      .bad   (bad_n)
   );

   for (genvar h = 0; h < MAX_HOPS; h++) begin : g_addr
      logic [KIND_W-1:0] k;
      assign k = kinds[h*KIND_W +: KIND_W];
      assign route_n[h*ADDR_W +: ADDR_W] =
         (k == EK_HOME) ? SELF_ADDR :
         (k == EK_NONE) ? '0 :
                          alloc_addr[h*ADDR_W +: ADDR_W];
   end

   assign alloc_kind = kinds;

   // ---------------- window slots ----------------
   pic_slot_pool #(
      .SLOTS (WINDOW),
      .TAG_W (TAG_W)
   ) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (fire),
      .give     (rx_valid),
      .give_tag (rx_tag),
      .has_free (any_free),
      .free_tag (pick_tag)
   );

   // ---------------- program counter ----------------
   pic_pc_steer #(
      .WORD_W   (WORD_W),
      .RESET_PC (RESET_PC),
      .TRAP_VEC (TRAP_VEC),
      .PC_STEP  (PC_STEP)
   ) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (fire),
      .ret_v      (rx_valid),
      .ret_fault  (rx_fault),
      .ret_branch (rx_class == CL_BRANCH),
      .ret_target (rx_target),
      .pc         (fetch_pc),
      .redir_hold (redir_hold)
   );

   // ---------------- issue handshake ----------------
   assign fet_ready  = any_free && dep_ok && !redir_hold && (!out_v || tx_ready);
   assign fire       = fet_valid && fet_ready;
   assign dep_claim  = fire;
   assign alloc_take = fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v    <= 1'b0;
         tx_route <= '0;
         tx_hops  <= '0;
         tx_instr <= '0;
         tx_pc    <= '0;
         tx_class <= '0;
         tx_tag   <= '0;
         tx_fault <= 1'b0;
      end else if (fire) begin
         out_v    <= 1'b1;
         tx_route <= route_n;
         tx_hops  <= hops_n;
         tx_instr <= fet_instr;
         tx_pc    <= fetch_pc;
         tx_class <= fet_class;
         tx_tag   <= pick_tag;
         tx_fault <= bad_n;
      end else if (tx_ready) begin
         out_v    <= 1'b0;
      end
   end

   assign tx_valid = out_v;
   assign tx_dest  = tx_route[ADDR_W-1:0];

   // ---------------- hazard release ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_valid <= 1'b0;
         rel_instr <= '0;
         rel_tag   <= '0;
      end else begin
         rel_valid <= rx_valid;
         rel_instr <= rx_instr;
         rel_tag   <= rx_tag;
      end
   end

   // ---------------- assertions ----------------
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_instr) && $stable(tx_tag) && $stable(tx_route)); // R6
   AST_LAST_HOP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_hops != '0 && tx_route[ADDR_W*(int'(tx_hops)-1) +: ADDR_W] == SELF_ADDR); // R2
   AST_FAULT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_fault |-> tx_hops == HOP_W'(1)); // R3
   AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rel_valid && rel_tag == $past(rx_tag)); // R11
   AST_REDIR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && (rx_fault || rx_class == CL_BRANCH) |=> !fet_ready); // R10

endmodule

// File: tb/tb_pkt_issue_ctrl.sv
module tb_pkt_issue_ctrl;

   localparam int WORD_W = 32;
   localparam int ADDR_W = 4;
   localparam int WINDOW = 16;
   localparam int MAX_HOPS = 5;
   localparam int TAG_W = 4;
   localparam int HOP_W = 3;
   localparam logic [ADDR_W-1:0] SELF = 4'd1;
   localparam logic [31:0] RST_PC = 32'h100;
   localparam logic [31:0] TRAP = 32'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [WORD_W-1:0] fetch_pc;
   logic fet_valid = 1'b0, fet_ready;
   logic [WORD_W-1:0] fet_instr = '0;
   logic [2:0] fet_class = '0;
   logic dep_ok = 1'b1, dep_claim;
   logic [MAX_HOPS*3-1:0] alloc_kind;
   logic [MAX_HOPS*ADDR_W-1:0] alloc_addr;
   logic alloc_take;
   logic tx_valid, tx_ready = 1'b1;
   logic [ADDR_W-1:0] tx_dest;
   logic [MAX_HOPS*ADDR_W-1:0] tx_route;
   logic [HOP_W-1:0] tx_hops;
   logic [WORD_W-1:0] tx_instr, tx_pc;
   logic [2:0] tx_class;
   logic [TAG_W-1:0] tx_tag;
   logic tx_fault;
   logic rx_valid = 1'b0;
   logic [WORD_W-1:0] rx_instr = '0;
   logic [2:0] rx_class = '0;
   logic [TAG_W-1:0] rx_tag = '0;
   logic rx_fault = 1'b0;
   logic [WORD_W-1:0] rx_target = '0;
   logic rel_valid;
   logic [WORD_W-1:0] rel_instr;
   logic [TAG_W-1:0] rel_tag;

   pkt_issue_ctrl dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .fet_valid(fet_valid), .fet_ready(fet_ready), .fet_instr(fet_instr), .fet_class(fet_class),
      .dep_ok(dep_ok), .dep_claim(dep_claim),
      .alloc_kind(alloc_kind), .alloc_addr(alloc_addr), .alloc_take(alloc_take),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dest(tx_dest), .tx_route(tx_route),
      .tx_hops(tx_hops), .tx_instr(tx_instr), .tx_pc(tx_pc), .tx_class(tx_class),
      .tx_tag(tx_tag), .tx_fault(tx_fault),
      .rx_valid(rx_valid), .rx_instr(rx_instr), .rx_class(rx_class), .rx_tag(rx_tag),
      .rx_fault(rx_fault), .rx_target(rx_target),
      .rel_valid(rel_valid), .rel_instr(rel_instr), .rel_tag(rel_tag)
   );

   // allocator model: address = kind + 8
   always_comb begin
      for (int i = 0; i < MAX_HOPS; i++)
         alloc_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(alloc_kind[i*3 +: 3]) + 4'd8;
   end

   int nchk = 0;
   int nbad = 0;
   bit done = 1'b0;
   logic [31:0] exp_pc;
   logic [31:0] issue_pc;

   task automatic eq(input string what, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // itinerary rows, nibble i = kind of hop i
   function automatic logic [19:0] row(input int c);
      case (c)
         0: return 20'h05121;
         1: return 20'h51421;
         2: return 20'h05421;
         3: return 20'h05131;
         4: return 20'h00521;
         5: return 20'h00512;
         default: return 20'h00005;
      endcase
   endfunction

   function automatic logic [19:0] exp_route(input int c);
      logic [19:0] r = row(c);
      logic [19:0] o = '0;
      for (int i = 0; i < 5; i++) begin
         logic [3:0] k = r[i*4 +: 4];
         o[i*4 +: 4] = (k == 0) ? 4'd0 : (k == 5) ? SELF : k + 4'd8;
      end
      return o;
   endfunction

   function automatic int exp_hops(input int c);
      logic [19:0] r = row(c);
      int n = 0;
      for (int i = 0; i < 5; i++) if (r[i*4 +: 4] != 0) n++;
      return n;
   endfunction

   task automatic issue(input logic [2:0] c, input logic [31:0] ins, output logic [TAG_W-1:0] tg);
      int n = 0;
      fet_class = c; fet_instr = ins; fet_valid = 1'b1;
      #1;
      while (!fet_ready && n < 40) begin
         @(negedge clk); #1; n++;
      end
      eq("R5 dep_claim at accept", 64'(dep_claim), 64'd1);
      issue_pc = fetch_pc;
      @(negedge clk);
      fet_valid = 1'b0;
      tg = tx_tag;
   endtask

   task automatic ret(input logic [TAG_W-1:0] tg, input logic [2:0] c, input logic f,
                      input logic [31:0] tgt, input logic [31:0] ins);
      rx_valid = 1'b1; rx_tag = tg; rx_class = c; rx_fault = f; rx_target = tgt; rx_instr = ins;
      @(negedge clk);
      rx_valid = 1'b0;
      eq("R11 rel_valid", 64'(rel_valid), 64'd1);
      eq("R11 rel_tag", 64'(rel_tag), 64'(tg));
      eq("R11 rel_instr", 64'(rel_instr), 64'(ins));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
         $finish;
      end
   end

   initial begin
      logic [TAG_W-1:0] tg, tb;
      logic [31:0] cpc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      eq("R7 reset pc", 64'(fetch_pc), 64'(RST_PC));
      eq("R1 reset tx_valid", 64'(tx_valid), 64'd0);
      eq("R4 reset ready", 64'(fet_ready), 64'd1);
      exp_pc = RST_PC;

      // class sweep
      for (int c = 0; c < 8; c++) begin
         logic [31:0] ins = 32'hA000_0000 | c;
         logic [31:0] tgt = 32'h300 + c * 16;
         issue(3'(c), ins, tg);
         eq("R1 tx_valid", 64'(tx_valid), 64'd1);
         eq("R1 tx_instr", 64'(tx_instr), 64'(ins));
         eq("R1 tx_pc", 64'(tx_pc), 64'(exp_pc));
         eq("R1 tx_class", 64'(tx_class), 64'(c));
         eq("R1 tx_dest", 64'(tx_dest), 64'(exp_route(c) & 20'hF));
         eq("R2 tx_route", 64'(tx_route), 64'(exp_route(c)));
         eq("R2 tx_hops", 64'(tx_hops), 64'(exp_hops(c)));
         eq("R3 tx_fault", 64'(tx_fault), 64'(c >= 6));
         eq("R4 tag lowest", 64'(tg), 64'd0);
         exp_pc = exp_pc + 4;
         eq("R7 pc step", 64'(fetch_pc), 64'(exp_pc));
         ret(tg, 3'(c), c >= 6, tgt, ins);
         if (c >= 6) exp_pc = TRAP;
         else if (c == 4) exp_pc = tgt;
         eq(c >= 6 ? "R8 trap pc" : "R9 pc after return", 64'(fetch_pc), 64'(exp_pc));
         if (c >= 4 && c != 5) eq("R10 stall after redirect", 64'(fet_ready), 64'd0);
      end

      // faulted branch: trap wins
      issue(3'd4, 32'hE4, tg);
      exp_pc = exp_pc + 4;
      ret(tg, 3'd4, 1'b1, 32'h600, 32'hE4);
      exp_pc = TRAP;
      eq("R8 faulted branch traps", 64'(fetch_pc), 64'(exp_pc));

      // fill the window
      for (int i = 0; i < WINDOW; i++) begin
         issue(3'd0, 32'hB00 + i, tg);
         eq("R4 tag order", 64'(tg), 64'(i));
         exp_pc = exp_pc + 4;
      end
      fet_valid = 1'b1; fet_class = 3'd0; fet_instr = 32'hBFF;
      #1;
      eq("R4 full window ready", 64'(fet_ready), 64'd0);
      @(negedge clk); @(negedge clk);
      eq("R4 no packet when full", 64'(tx_valid), 64'd0);
      eq("R4 pc frozen when full", 64'(fetch_pc), 64'(exp_pc));
      fet_valid = 1'b0;
      ret(4'd5, 3'd0, 1'b0, 32'h0, 32'hB05);
      issue(3'd0, 32'hBAA, tg);
      eq("R4 freed slot reused", 64'(tg), 64'd5);
      exp_pc = exp_pc + 4;
      for (int t = 0; t < WINDOW; t++) ret(4'(t), 3'd0, 1'b0, 32'h0, 32'hCC);
      eq("R4 ready after drain", 64'(fet_ready), 64'd1);

      // dependency stall
      dep_ok = 1'b0; fet_valid = 1'b1; fet_class = 3'd0; fet_instr = 32'hDD;
      #1;
      eq("R5 ready low on hazard", 64'(fet_ready), 64'd0);
      eq("R5 no claim on hazard", 64'(dep_claim), 64'd0);
      @(negedge clk); @(negedge clk);
      eq("R5 no packet on hazard", 64'(tx_valid), 64'd0);
      eq("R5 pc held on hazard", 64'(fetch_pc), 64'(exp_pc));
      fet_valid = 1'b0; dep_ok = 1'b1;
      issue(3'd2, 32'hD2, tg);
      exp_pc = exp_pc + 4;
      eq("R5 issue after hazard clears", 64'(tx_instr), 64'hD2);
      ret(tg, 3'd2, 1'b0, 32'h0, 32'hD2);

      // output backpressure
      tx_ready = 1'b0;
      issue(3'd1, 32'hC1, tg);
      exp_pc = exp_pc + 4;
      fet_valid = 1'b1; fet_class = 3'd3; fet_instr = 32'hC3;
      #1;
      eq("R6 ready low while blocked", 64'(fet_ready), 64'd0);
      repeat (3) @(negedge clk);
      eq("R6 valid held", 64'(tx_valid), 64'd1);
      eq("R6 instr held", 64'(tx_instr), 64'hC1);
      eq("R6 tag held", 64'(tx_tag), 64'(tg));
      eq("R6 route held", 64'(tx_route), 64'(exp_route(1)));
      eq("R6 pc held", 64'(fetch_pc), 64'(exp_pc));
      fet_valid = 1'b0; tx_ready = 1'b1;
      @(negedge clk);
      eq("R6 packet leaves", 64'(tx_valid), 64'd0);
      ret(tg, 3'd1, 1'b0, 32'h0, 32'hC1);

      // collision: acceptance and branch return in one cycle
      issue(3'd4, 32'hD4, tb);
      exp_pc = exp_pc + 4;
      fet_valid = 1'b1; fet_class = 3'd0; fet_instr = 32'hD0;
      rx_valid = 1'b1; rx_tag = tb; rx_class = 3'd4; rx_fault = 1'b0;
      rx_target = 32'h500; rx_instr = 32'hD4;
      #1;
      eq("R10 collision ready", 64'(fet_ready), 64'd1);
      cpc = fetch_pc;
      @(negedge clk);
      fet_valid = 1'b0; rx_valid = 1'b0;
      eq("R10 redirect beats step", 64'(fetch_pc), 64'h500);
      eq("R1 collision tx_pc", 64'(tx_pc), 64'(cpc));
      eq("R4 collision tag", 64'(tx_tag), 64'(tb + 4'd1));
      eq("R11 collision release", 64'(rel_tag), 64'(tb));
      eq("R10 stall after collision", 64'(fet_ready), 64'd0);
      ret(tb + 4'd1, 3'd0, 1'b0, 32'h0, 32'hD0);
      exp_pc = 32'h500;
      issue(3'd5, 32'hD5, tg);
      eq("R7 pc after redirect", 64'(tx_pc), 64'(exp_pc));
      ret(tg, 3'd5, 1'b0, 32'h0, 32'hD5);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

endmodule